// File: doc/BRIEF.md
# Multi-Channel Countdown Timer with Shared Prescaler

This block is a memory-mapped timer peripheral. It holds a bank of independent countdown channels and one wide free-running counter. All of them are reached through a simple synchronous register bus. A write takes effect on the clock edge that samples it. A read returns data combinationally for the address that is presented. A read strobe marks the cycle in which the read is consumed.

A single prescaler divides the input clock by N+1, and every channel counts on its ticks. Each channel decrements its count once per tick while it is enabled. When it expires it raises a pending flag. It then either stops at zero (one-shot) or reloads from its reload register and keeps going (periodic). Each channel has its own interrupt line, which is active high.

The free-running counter advances on every input clock while its enable is set, and software reads it as two 32-bit words. Reading the low word captures the high word into a snapshot register. The later high-word read returns that snapshot, so a carry between the two reads cannot produce a torn value.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero and every interrupt line is low.
- R2: Address map (byte offsets):
  - 0x00 is general control: bit 0 enables the free-running counter, bit 2 enables the prescaler, and the other bits read zero.
  - 0x04 holds the prescale value N.
  - Channel i sits at 0x10 + 0x10*i, with count at +0x0, reload at +0x4 and config at +0x8.
  - The free-running counter low word is at 0xE8 and its high word is at 0xEC.
  - Unmapped addresses read zero.
- R3: Channel config fields: bit 0 enable, bit 1 restart (periodic), bit 2 interrupt enable, bit 4 pending. Every other bit reads zero.
- R4: While enabled, the prescaler issues one tick every N+1 input clocks, with the first tick N+1 clocks after it is enabled. No channel changes its count while the prescaler is disabled.
- R5: Countdown rules for an enabled channel on a tick:
  - If the count is above 1, it decrements by one.
  - If the count is 1, the channel expires: pending is set, and the count becomes the reload value if restart is set, or zero otherwise.
  - In periodic mode, a tick at count 0 is also an expiry.
- R6: In one-shot mode the count stays at zero after expiry. Writing zero to the config register disables the channel and clears pending.
- R7: In periodic mode the channel keeps running and sets pending on every expiry. Writing config with bit 4 at 0 clears pending, and writing bit 4 at 1 leaves it unchanged.
- R8: A channel's interrupt line is high exactly when both its pending bit and its interrupt-enable bit are set.
- R9: A write to a count register loads it on that edge and takes priority over a same-cycle tick. An expiry in the same cycle as a config write still sets pending.
- R10: The free-running counter increments by one on every clock while enabled and holds otherwise. Writes to its addresses are ignored.
- R11: Reading the low word latches the current high word into a snapshot. Reads of the high word return that snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (consumes a read, needed for the low-word snapshot) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | NUM_CH | Per-channel level-high interrupt |

## Verification
The bound checker watches several rules on every cycle:
- ticks are spaced apart whenever N is nonzero;
- a channel count holds when there is neither a tick nor a write;
- a stopped one-shot channel stays at zero;
- pending stays set until a config write;
- the free-running counter steps or holds according to its enable;
- the snapshot equals the high word as it stood at the low-word read.

Other behaviour depends on exact cycle counts or on the register map, and only the bench scenarios can show it. This covers the expiry cycle under different prescale values, periodic reload spacing, clear-by-zero semantics, write priority over a tick, and field masking on readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned DW          = 32;
   localparam int unsigned OFS_GEN     = 'h00;
   localparam int unsigned OFS_PRE     = 'h04;
   localparam int unsigned OFS_CH0     = 'h10;
   localparam int unsigned CH_STRIDE   = 'h10;
   localparam int unsigned OFS_CNT     = 'h0;
   localparam int unsigned OFS_RLD     = 'h4;
   localparam int unsigned OFS_CFG     = 'h8;
   localparam int unsigned OFS_FRC_LO  = 'hE8;
   localparam int unsigned OFS_FRC_HI  = 'hEC;

   localparam int unsigned CB_EN       = 0;
   localparam int unsigned CB_RESTART  = 1;
   localparam int unsigned CB_IE       = 2;
   localparam int unsigned CB_PEND     = 4;
   localparam int unsigned GB_FRC      = 0;
   localparam int unsigned GB_PRE      = 2;

   typedef struct packed {
      logic pend;
      logic ie;
      logic restart;
      logic en;
   } ch_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned PW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [PW-1:0] div_n,
   output logic          tick
);
   logic [PW-1:0] phase;

   assign tick = en && (phase >= div_n);

   always_ff @(posedge clk) begin
      if (!rst_n)            phase <= '0;
      else if (!en || tick)  phase <= '0;
      else                   phase <= phase + 1'b1;
   end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int unsigned CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          cnt_we,
   input  logic          rld_we,
   input  logic          cfg_we,
   input  logic [CW-1:0] wdata,
   input  ch_cfg_t       cfg_wdata,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] rld_q,
   output ch_cfg_t       cfg_q,
   output logic          irq
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic step, expire;

   assign step   = cfg_q.en && tick && !cnt_we;
   assign expire = step && ((cnt_q == ONE) || (cnt_q == '0 && cfg_q.restart));
   assign irq    = cfg_q.pend && cfg_q.ie;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rld_q <= '0;
         cfg_q <= '0;
      end else begin
         if (cnt_we)                 cnt_q <= wdata;
         else if (expire)            cnt_q <= cfg_q.restart ? rld_q : '0;
         else if (step && cnt_q != '0) cnt_q <= cnt_q - ONE;

         if (rld_we) rld_q <= wdata;

         if (cfg_we) begin
            cfg_q.en      <= cfg_wdata.en;
            cfg_q.restart <= cfg_wdata.restart;
            cfg_q.ie      <= cfg_wdata.ie;
            cfg_q.pend    <= (cfg_q.pend && cfg_wdata.pend) || expire;
         end else if (expire) begin
            cfg_q.pend    <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun #(
   parameter int unsigned FW = 64,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          lo_rd,
   output logic [FW-1:0] cnt,
   output logic [DW-1:0] hi_snap
);
   localparam int unsigned HW = FW - DW;

   logic [DW-1:0] hi_ext;

   generate
      if (HW == DW) begin : g_full
         assign hi_ext = cnt[FW-1:DW];
      end else begin : g_pad
         assign hi_ext = {{(DW-HW){1'b0}}, cnt[FW-1:DW]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         hi_snap <= '0;
      end else begin
         if (en)    cnt     <= cnt + 1'b1;
         if (lo_rd) hi_snap <= hi_ext;
      end
   end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned CW     = 32,
   parameter int unsigned PW     = 32,
   parameter int unsigned FW     = 64,
   parameter int unsigned AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_rd,
   input  logic [AW-1:0]     bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int unsigned CH_END = OFS_CH0 + NUM_CH * CH_STRIDE;

   initial begin
      if (NUM_CH < 1 || CH_END > OFS_FRC_LO) $fatal(1, "tmr_bank: NUM_CH out of range");
      if (CW < 2 || CW > DW)                 $fatal(1, "tmr_bank: CW out of range");
      if (PW < 1 || PW > DW)                 $fatal(1, "tmr_bank: PW out of range");
      if (FW <= DW || FW > 2 * DW)           $fatal(1, "tmr_bank: FW out of range");
      if ((1 << AW) <= OFS_FRC_HI)           $fatal(1, "tmr_bank: AW too small");
   end

   logic          frc_en, pre_en, tick, frc_lo_rd;
   logic [PW-1:0] pre_div;
   logic [FW-1:0] frc_cnt;
   logic [DW-1:0] frc_shadow;

   logic [CW-1:0]     ch_cnt [NUM_CH];
   logic [CW-1:0]     ch_rld [NUM_CH];
   ch_cfg_t           ch_cfg [NUM_CH];
   logic [NUM_CH-1:0] cnt_we, rld_we, cfg_we;
   logic [NUM_CH-1:0] ch_en, ch_restart, ch_pend;

   ch_cfg_t cfg_wdata;
   assign cfg_wdata = '{pend:    bus_wdata[CB_PEND],
                        ie:      bus_wdata[CB_IE],
                        restart: bus_wdata[CB_RESTART],
                        en:      bus_wdata[CB_EN]};

   assign frc_lo_rd = bus_rd && (bus_addr == AW'(OFS_FRC_LO));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frc_en  <= 1'b0;
         pre_en  <= 1'b0;
         pre_div <= '0;
      end else if (bus_we) begin
         if (bus_addr == AW'(OFS_GEN)) begin
            frc_en <= bus_wdata[GB_FRC];
            pre_en <= bus_wdata[GB_PRE];
         end
         if (bus_addr == AW'(OFS_PRE)) pre_div <= bus_wdata[PW-1:0];
      end
   end

   tmr_prescale #(.PW(PW)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(pre_en), .div_n(pre_div), .tick(tick)
   );

   tmr_freerun #(.FW(FW), .DW(DW)) u_frc (
      .clk(clk), .rst_n(rst_n), .en(frc_en), .lo_rd(frc_lo_rd),
      .cnt(frc_cnt), .hi_snap(frc_shadow)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         localparam int unsigned BASE = OFS_CH0 + i * CH_STRIDE;
         assign cnt_we[i] = bus_we && (bus_addr == AW'(BASE + OFS_CNT));
         assign rld_we[i] = bus_we && (bus_addr == AW'(BASE + OFS_RLD));
         assign cfg_we[i] = bus_we && (bus_addr == AW'(BASE + OFS_CFG));

         tmr_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .cnt_we(cnt_we[i]), .rld_we(rld_we[i]), .cfg_we(cfg_we[i]),
            .wdata(bus_wdata[CW-1:0]), .cfg_wdata(cfg_wdata),
            .cnt_q(ch_cnt[i]), .rld_q(ch_rld[i]), .cfg_q(ch_cfg[i]),
            .irq(irq[i])
         );

         assign ch_en[i]      = ch_cfg[i].en;
         assign ch_restart[i] = ch_cfg[i].restart;
         assign ch_pend[i]    = ch_cfg[i].pend;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(OFS_GEN)) begin
         bus_rdata[GB_FRC] = frc_en;
         bus_rdata[GB_PRE] = pre_en;
      end
      if (bus_addr == AW'(OFS_PRE))    bus_rdata = DW'(pre_div);
      if (bus_addr == AW'(OFS_FRC_LO)) bus_rdata = frc_cnt[DW-1:0];
      if (bus_addr == AW'(OFS_FRC_HI)) bus_rdata = frc_shadow;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == AW'(OFS_CH0 + i * CH_STRIDE + OFS_CNT)) bus_rdata = DW'(ch_cnt[i]);
         if (bus_addr == AW'(OFS_CH0 + i * CH_STRIDE + OFS_RLD)) bus_rdata = DW'(ch_rld[i]);
         if (bus_addr == AW'(OFS_CH0 + i * CH_STRIDE + OFS_CFG)) begin
            bus_rdata[CB_EN]      = ch_cfg[i].en;
            bus_rdata[CB_RESTART] = ch_cfg[i].restart;
            bus_rdata[CB_IE]      = ch_cfg[i].ie;
            bus_rdata[CB_PEND]    = ch_cfg[i].pend;
         end
      end
   end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned CW     = 32,
   parameter int unsigned PW     = 32,
   parameter int unsigned FW     = 64,
   parameter int unsigned DW     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [PW-1:0]     pre_div,
   input logic              frc_en,
   input logic              frc_lo_rd,
   input logic [FW-1:0]     frc_cnt,
   input logic [DW-1:0]     frc_shadow,
   input logic [CW-1:0]     ch_cnt [NUM_CH],
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] ch_restart,
   input logic [NUM_CH-1:0] ch_pend,
   input logic [NUM_CH-1:0] cnt_we,
   input logic [NUM_CH-1:0] cfg_we
);
   // R4: with N above zero, two ticks never fall on adjacent clocks
   a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && pre_div != '0) |=> !tick);

   // R10: counter steps by one while enabled
   a_r10_frc_step: assert property (@(posedge clk) disable iff (!rst_n)
      frc_en |=> (frc_cnt == $past(frc_cnt) + FW'(1)));

   // R10: counter holds while disabled
   a_r10_frc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frc_en |=> $stable(frc_cnt));

   // R11: snapshot equals the high word seen at the low-word read
   a_r11_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      frc_lo_rd |=> (frc_shadow == DW'($past(frc_cnt) >> DW)));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
         // R4, R5: no tick and no write means the count holds
         a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && !cnt_we[i]) |=> $stable(ch_cnt[i]));

         // R6: a stopped one-shot channel stays at zero
         a_r6_oneshot_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && !ch_restart[i] && ch_cnt[i] == '0 && !cnt_we[i]) |=> (ch_cnt[i] == '0));

         // R7: pending only drops through a config write
         a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_pend[i] && !cfg_we[i]) |=> ch_pend[i]);
      end
   endgenerate
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .CW(CW), .PW(PW), .FW(FW), .DW(tmr_pkg::DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .pre_div(pre_div),
   .frc_en(frc_en), .frc_lo_rd(frc_lo_rd), .frc_cnt(frc_cnt), .frc_shadow(frc_shadow),
   .ch_cnt(ch_cnt), .ch_en(ch_en), .ch_restart(ch_restart), .ch_pend(ch_pend),
   .cnt_we(cnt_we), .cfg_we(cfg_we)
);

// File: tb/tb_tmr_bank.sv
`timescale 1ns/1ps
module tb_tmr_bank;
   localparam int NUM_CH = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic              bus_rd = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NUM_CH-1:0] irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   tmr_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // {req, op(0 write / 1 read-compare), addr, data}
   localparam int NV = 19;
   localparam logic [44:0] VEC [NV] = '{
      {4'd2,  1'b0, 8'h14, 32'h1234_5678},  // R2 ch0 reload
      {4'd2,  1'b1, 8'h14, 32'h1234_5678},
      {4'd2,  1'b0, 8'h84, 32'hA5A5_0001},  // R2 ch7 reload
      {4'd2,  1'b1, 8'h84, 32'hA5A5_0001},
      {4'd2,  1'b1, 8'h14, 32'h1234_5678},  // R2 channels independent
      {4'd3,  1'b0, 8'h18, 32'hFFFF_FFFF},
      {4'd3,  1'b1, 8'h18, 32'h0000_0007},  // R3 mask, R7 pend write-one ignored
      {4'd9,  1'b0, 8'h10, 32'h0000_0003},
      {4'd4,  1'b1, 8'h10, 32'h0000_0003},  // R4 no advance, prescaler off
      {4'd6,  1'b0, 8'h18, 32'h0000_0000},
      {4'd6,  1'b1, 8'h18, 32'h0000_0000},
      {4'd2,  1'b0, 8'h00, 32'hFFFF_FFFA},
      {4'd2,  1'b1, 8'h00, 32'h0000_0000},  // R2 general mask
      {4'd2,  1'b0, 8'h04, 32'h0000_0007},
      {4'd2,  1'b1, 8'h04, 32'h0000_0007},
      {4'd10, 1'b0, 8'hE8, 32'h0000_DEAD},
      {4'd10, 1'b1, 8'hE8, 32'h0000_0000},  // R10 write ignored
      {4'd2,  1'b1, 8'hF0, 32'h0000_0000},  // R2 unmapped
      {4'd2,  1'b0, 8'h04, 32'h0000_0000}
   };

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog all actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, v1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1", "irq", 64'(irq), 64'h0);
      rd(8'h00, d); chk("R1", "gen", 64'(d), 64'h0);
      rd(8'h18, d); chk("R1", "cfg0", 64'(d), 64'h0);
      rd(8'hE8, d); chk("R1", "frc", 64'(d), 64'h0);

      // vector table
      for (int k = 0; k < NV; k++) begin
         if (VEC[k][40] == 1'b0) wr(VEC[k][39:32], VEC[k][31:0]);
         else begin
            rd(VEC[k][39:32], d);
            chk($sformatf("R%0d", VEC[k][44:41]), $sformatf("addr %0h", VEC[k][39:32]),
                64'(d), 64'(VEC[k][31:0]));
         end
      end

      // R5 R6 R8: one-shot, N=0, channel 1
      wr(8'h00, 32'h4);
      wr(8'h20, 32'd3);
      wr(8'h28, 32'h5);
      waitc(2); chk("R5", "irq before expiry", 64'(irq), 64'h0);
      waitc(1); chk("R8", "irq at expiry", 64'(irq), 64'h2);
      rd(8'h20, d); chk("R6", "count stopped", 64'(d), 64'h0);
      waitc(3);
      rd(8'h20, d); chk("R6", "count still zero", 64'(d), 64'h0);
      rd(8'h28, d); chk("R3", "cfg with pending", 64'(d), 64'h15);
      wr(8'h28, 32'h0); chk("R6", "irq after clear", 64'(irq), 64'h0);
      rd(8'h28, d); chk("R6", "cfg cleared", 64'(d), 64'h0);

      // R4 R7: periodic, N=2, channel 2
      wr(8'h00, 32'h0);
      wr(8'h04, 32'd2);
      wr(8'h30, 32'd2);
      wr(8'h34, 32'd2);
      wr(8'h38, 32'h7);
      wr(8'h00, 32'h4);
      waitc(5); chk("R4", "no expiry yet", 64'(irq[2]), 64'h0);
      waitc(1); chk("R4", "expiry after 2 ticks", 64'(irq[2]), 64'h1);
      wr(8'h38, 32'h7); chk("R7", "pending cleared", 64'(irq[2]), 64'h0);
      waitc(4); chk("R7", "reloaded, not yet", 64'(irq[2]), 64'h0);
      waitc(1); chk("R7", "second expiry", 64'(irq[2]), 64'h1);
      wr(8'h38, 32'h17); chk("R7", "write one keeps pending", 64'(irq[2]), 64'h1);
      wr(8'h38, 32'h13); chk("R8", "ie off masks irq", 64'(irq[2]), 64'h0);
      rd(8'h38, d); chk("R8", "pending retained", 64'(d), 64'h13);
      wr(8'h38, 32'h0);

      // R9: count write beats same-cycle tick, N=0, channel 3
      wr(8'h04, 32'd0);
      wr(8'h40, 32'd100);
      wr(8'h48, 32'h1);
      wr(8'h40, 32'd50);
      rd(8'h40, d); chk("R9", "count write priority", 64'(d), 64'd50);
      wr(8'h48, 32'h0);

      // R10 R11: free-running counter
      wr(8'h00, 32'h1);
      rd(8'hE8, d);  chk("R10", "frc first", 64'(d), 64'd0);
      rd(8'hE8, d);  chk("R10", "frc step", 64'(d), 64'd1);
      waitc(10);
      rd(8'hE8, d);  chk("R10", "frc span", 64'(d), 64'd12);
      rd(8'hEC, d);  chk("R11", "high snapshot", 64'(d), 64'd0);
      wr(8'h00, 32'h0);
      rd(8'hE8, v1); chk("R10", "frc stopped", 64'(v1), 64'd15);
      wr(8'hE8, 32'h5);
      rd(8'hE8, d);  chk("R10", "frc write ignored", 64'(d), 64'd15);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule